// File: doc/BRIEF.md
# Fused Multiply-Add Exception Accumulator

This block turns the IEEE condition flags of the two chained stages of a fused multiply-add into one update of a floating-point status word. The first stage is the multiply and the second is the add/subtract. The status word holds a current-exception field and an accrued-exception field. For each operation the block does one of three things: it raises an IEEE trap, it raises an unfinished-operation trap so that software can finish the operation, or it completes normally and enables the result writeback. The arithmetic datapaths sit outside the block. Only their condition flags enter it.

Each stage reports a 5-bit flag vector. The bit order is {invalid, overflow, underflow, divide-by-zero, inexact}, so invalid is bit 4, overflow bit 3, underflow bit 2, divide-by-zero bit 1 and inexact bit 0. The trap-enable mask and both status fields use the same order. A mode input selects non-standard underflow handling. A valid strobe marks the cycle in which a set of stage flags is presented. All outputs are registered and change at the clock edge that samples the strobe.

Top module: `fmax_exc_accum`

## Requirements
- R1: An operation is unfinished when the unfinished request is high, or when the mode bit is 0 and either stage reports underflow (bit 2). An unfinished operation produces trap kind 2'b10 and leaves the current field, the accrued field and the writeback enable unchanged, with writeback low. This rule has priority over all others.
- R2: A stage traps when its raw flags ANDed with the enable mask are non-zero. If the multiply stage traps, the current field is loaded with the multiply stage's reported flags only, the accrued field is unchanged, writeback is low, and trap kind is 2'b01.
- R3: If the multiply stage does not trap and the add stage does, the current field is loaded with the add stage's reported flags only, the accrued field is unchanged, writeback is low, and trap kind is 2'b01.
- R4: If no stage traps, the current field becomes the OR of both stages' reported flags, the accrued field becomes its old value ORed with the new current field, and writeback is high for one cycle.
- R5: A stage's reported flags always include inexact (bit 0) when that stage shows overflow (bit 3) or underflow (bit 2).
- R6: With the mode bit 1, underflow is not diverted. It appears in the current field as underflow together with inexact.
- R7: An invalid from one stage is reported together with the overflow and inexact of the other stage. For example, multiply invalid with add overflow gives bits 4, 3 and 0 set.
- R8: After synchronous reset both fields are zero, and writeback and the trap pulse are low.
- R9: A cycle without the valid strobe changes neither field and produces no trap pulse and no writeback.
- R10: The trap pulse lasts one cycle per operation. Trap kind is 2'b00 when there is no trap. The trap pulse and writeback are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Stage flags valid this cycle |
| unfin_req | input | 1 | External unfinished-operation request |
| mul_flags | input | 5 | Multiply stage conditions {nv,of,uf,dz,nx} |
| add_flags | input | 5 | Add/subtract stage conditions {nv,of,uf,dz,nx} |
| trap_en | input | 5 | Trap enable mask, same bit order |
| ns_mode | input | 1 | Non-standard underflow mode |
| cexc | output | 5 | Current-exception field |
| aexc | output | 5 | Accrued-exception field |
| wb_en | output | 1 | Result writeback enable |
| trap_pulse | output | 1 | One-cycle trap indication |
| trap_kind | output | 2 | 01 IEEE trap, 10 unfinished trap, 00 none |

## Verification
The hardest case to reach is the interaction between the two stages: a multiply-stage trap must hide add-stage flags that would also trap, while the accrued field must still reflect every earlier non-trapping operation. The stimulus sweeps every pair of multiply and add flag vectors under each single-bit enable mask, with no enables, and in both modes. It mixes in unfinished requests and idle cycles. This produces every priority collision, and the accrued field carries a history that the bench model tracks across the whole sweep.

// File: rtl/fmax_pkg.sv
package fmax_pkg;
  localparam int FLAG_W = 5;
  localparam int B_NV = 4;
  localparam int B_OF = 3;
  localparam int B_UF = 2;
  localparam int B_DZ = 1;
  localparam int B_NX = 0;

  typedef logic [FLAG_W-1:0] flags_t;

  typedef enum logic [1:0] {
    TK_NONE  = 2'b00,
    TK_IEEE  = 2'b01,
    TK_UNFIN = 2'b10
  } trap_kind_t;

  // Reported view of one stage: overflow or underflow always brings inexact.
  function automatic flags_t report_view(input flags_t raw);
    flags_t v;
    v = raw;
    if (raw[B_OF] || raw[B_UF]) v[B_NX] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/fmax_stage_eval.sv
module fmax_stage_eval
  import fmax_pkg::*;
(
  input  flags_t raw,
  input  flags_t enable,
  input  logic   ns_mode,
  output flags_t reported,
  output logic   traps,
  output logic   divert
);
  always_comb begin
    reported = report_view(raw);
    // Trap test uses the raw flags, before inexact is implied.
    traps    = |(raw & enable);
    // Without non-standard mode, underflow goes to software.
    divert   = raw[B_UF] && !ns_mode;
  end
endmodule

// File: rtl/fmax_resolve.sv
module fmax_resolve
  import fmax_pkg::*;
#(
  parameter int NUM_STAGES = 2
) (
  input  logic                         valid,
  input  logic                         unfin_req,
  input  logic [NUM_STAGES-1:0][FLAG_W-1:0] reported,
  input  logic [NUM_STAGES-1:0]        traps,
  input  logic [NUM_STAGES-1:0]        divert,
  input  flags_t                       aexc_cur,
  output flags_t                       cexc_nxt,
  output flags_t                       aexc_nxt,
  output logic                         cexc_upd,
  output logic                         aexc_upd,
  output logic                         wb,
  output trap_kind_t                   kind
);
  localparam int SEL_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;

  logic [SEL_W-1:0] sel;
  logic             any_trap;
  flags_t           merged;

  // Earliest stage in the chain wins: scan downward so index 0 is last.
  always_comb begin
    sel      = '0;
    any_trap = 1'b0;
    merged   = '0;
    for (int i = NUM_STAGES - 1; i >= 0; i--) begin
      merged = merged | reported[i];
      if (traps[i]) begin
        sel      = SEL_W'(i);
        any_trap = 1'b1;
      end
    end
  end

  always_comb begin
    cexc_nxt = '0;
    aexc_nxt = aexc_cur;
    cexc_upd = 1'b0;
    aexc_upd = 1'b0;
    wb       = 1'b0;
    kind     = TK_NONE;
    if (valid) begin
      if (unfin_req || (|divert)) begin
        kind = TK_UNFIN;
      end else if (any_trap) begin
        kind     = TK_IEEE;
        cexc_upd = 1'b1;
        cexc_nxt = reported[sel];
      end else begin
        cexc_upd = 1'b1;
        aexc_upd = 1'b1;
        wb       = 1'b1;
        cexc_nxt = merged;
        aexc_nxt = aexc_cur | merged;
      end
    end
  end
endmodule

// File: rtl/fmax_status_reg.sv
module fmax_status_reg
  import fmax_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  flags_t     cexc_nxt,
  input  flags_t     aexc_nxt,
  input  logic       cexc_upd,
  input  logic       aexc_upd,
  input  logic       wb_nxt,
  input  trap_kind_t kind_nxt,
  output flags_t     cexc,
  output flags_t     aexc,
  output logic       wb_en,
  output logic       trap_pulse,
  output trap_kind_t trap_kind
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cexc       <= '0;
      aexc       <= '0;
      wb_en      <= 1'b0;
      trap_pulse <= 1'b0;
      trap_kind  <= TK_NONE;
    end else begin
      if (cexc_upd) cexc <= cexc_nxt;
      if (aexc_upd) aexc <= aexc_nxt;
      wb_en      <= wb_nxt;
      trap_pulse <= (kind_nxt != TK_NONE);
      trap_kind  <= kind_nxt;
    end
  end

  AST_UNFIN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (trap_pulse && trap_kind == TK_UNFIN) |-> ($stable(cexc) && $stable(aexc) && !wb_en)); // R1
  AST_IEEE_AEXC_KEPT: assert property (@(posedge clk) disable iff (rst)
    (trap_pulse && trap_kind == TK_IEEE) |-> ($stable(aexc) && !wb_en)); // R2
  AST_AEXC_ACCUM: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (aexc == ($past(aexc) | cexc))); // R4
  AST_OF_HAS_NX: assert property (@(posedge clk) disable iff (rst)
    cexc[B_OF] |-> cexc[B_NX]); // R5
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wb_en, trap_pulse})); // R10
  AST_KIND_MATCH: assert property (@(posedge clk) disable iff (rst)
    trap_pulse == (trap_kind != TK_NONE)); // R10
endmodule

// File: rtl/fmax_exc_accum.sv
module fmax_exc_accum
  import fmax_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       op_valid,
  input  logic       unfin_req,
  input  logic [4:0] mul_flags,
  input  logic [4:0] add_flags,
  input  logic [4:0] trap_en,
  input  logic       ns_mode,
  output logic [4:0] cexc,
  output logic [4:0] aexc,
  output logic       wb_en,
  output logic       trap_pulse,
  output logic [1:0] trap_kind
);
  localparam int NUM_STAGES = 2;

  logic [NUM_STAGES-1:0][FLAG_W-1:0] stage_raw;
  logic [NUM_STAGES-1:0][FLAG_W-1:0] stage_rep;
  logic [NUM_STAGES-1:0]             stage_trap;
  logic [NUM_STAGES-1:0]             stage_div;

  flags_t     cexc_nxt, aexc_nxt, cexc_q, aexc_q;
  logic       cexc_upd, aexc_upd, wb_nxt;
  trap_kind_t kind_nxt, kind_q;

  // Stage 0 is the multiply, stage 1 the add/subtract.
  assign stage_raw[0] = mul_flags;
  assign stage_raw[1] = add_flags;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    fmax_stage_eval u_eval (
      .raw      (stage_raw[g]),
      .enable   (trap_en),
      .ns_mode  (ns_mode),
      .reported (stage_rep[g]),
      .traps    (stage_trap[g]),
      .divert   (stage_div[g])
    );
  end

  fmax_resolve #(.NUM_STAGES(NUM_STAGES)) u_resolve (
    .valid    (op_valid),
    .unfin_req(unfin_req),
    .reported (stage_rep),
    .traps    (stage_trap),
    .divert   (stage_div),
    .aexc_cur (aexc_q),
    .cexc_nxt (cexc_nxt),
    .aexc_nxt (aexc_nxt),
    .cexc_upd (cexc_upd),
    .aexc_upd (aexc_upd),
    .wb       (wb_nxt),
    .kind     (kind_nxt)
  );

  fmax_status_reg u_status (
    .clk       (clk),
    .rst       (rst),
    .cexc_nxt  (cexc_nxt),
    .aexc_nxt  (aexc_nxt),
    .cexc_upd  (cexc_upd),
    .aexc_upd  (aexc_upd),
    .wb_nxt    (wb_nxt),
    .kind_nxt  (kind_nxt),
    .cexc      (cexc_q),
    .aexc      (aexc_q),
    .wb_en     (wb_en),
    .trap_pulse(trap_pulse),
    .trap_kind (kind_q)
  );

  assign cexc      = cexc_q;
  assign aexc      = aexc_q;
  assign trap_kind = kind_q;

  AST_NS0_NO_UF: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (!cexc[B_UF] || $past(ns_mode))); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!trap_pulse && !wb_en && $stable(aexc) && $stable(cexc))); // R9
endmodule

// File: tb/test_fmax_exc_accum.sv
module test_fmax_exc_accum;
  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid, unfin_req, ns_mode;
  logic [4:0] mul_flags, add_flags, trap_en;
  logic [4:0] cexc, aexc;
  logic       wb_en, trap_pulse;
  logic [1:0] trap_kind;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [4:0] e_cexc, e_aexc;

  always #2.5 clk = ~clk;

  fmax_exc_accum i_fmax_exc_accum (
    .clk(clk), .rst(rst), .op_valid(op_valid), .unfin_req(unfin_req),
    .mul_flags(mul_flags), .add_flags(add_flags), .trap_en(trap_en),
    .ns_mode(ns_mode), .cexc(cexc), .aexc(aexc), .wb_en(wb_en),
    .trap_pulse(trap_pulse), .trap_kind(trap_kind)
  );

  task automatic chk(input string tag, input bit ok, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] rep(input logic [4:0] f);
    return f | ((f[3] | f[2]) ? 5'b00001 : 5'b00000);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0; unfin_req = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    e_cexc = '0; e_aexc = '0;
    chk("R8", cexc == 0 && aexc == 0 && !wb_en && !trap_pulse && trap_kind == 0,
        {cexc, aexc, wb_en, trap_pulse, trap_kind, 2'b0}, 16'h0);
  endtask

  // Drive one vector, advance one cycle, compare with the arithmetic model.
  task automatic step(input bit v, input bit uf_req, input logic [4:0] m,
                      input logic [4:0] a, input logic [4:0] en, input bit ns);
    logic [4:0] rm, ra;
    bit unf, mt, at, e_wb;
    logic [1:0] e_kind;
    string tag;
    op_valid = v; unfin_req = uf_req; mul_flags = m; add_flags = a;
    trap_en = en; ns_mode = ns;
    rm = rep(m); ra = rep(a);
    unf = uf_req || (!ns && (m[2] || a[2]));
    mt = |(m & en); at = |(a & en);
    e_wb = 1'b0; e_kind = 2'b00;
    if (!v)          begin tag = "R9"; end
    else if (unf)    begin tag = "R1"; e_kind = 2'b10; end
    else if (mt)     begin tag = "R2"; e_kind = 2'b01; e_cexc = rm; end
    else if (at)     begin tag = "R3"; e_kind = 2'b01; e_cexc = ra; end
    else begin
      tag = "R4"; e_wb = 1'b1; e_cexc = rm | ra; e_aexc = e_aexc | e_cexc;
    end
    @(negedge clk);
    chk(tag, cexc == e_cexc && aexc == e_aexc && wb_en == e_wb &&
             trap_kind == e_kind && trap_pulse == (e_kind != 0),
        {cexc, aexc, wb_en, trap_kind, 3'b0}, {e_cexc, e_aexc, e_wb, e_kind, 3'b0});
    chk("R10", !(wb_en && trap_pulse), {14'b0, wb_en, trap_pulse}, 16'h0);
    if (e_wb && (m[3] || a[3]))
      chk("R5", cexc[3] && cexc[0], {11'b0, cexc}, {11'b0, e_cexc});
    if (e_wb && ns && (m[2] || a[2]))
      chk("R6", cexc[2] && cexc[0], {11'b0, cexc}, {11'b0, e_cexc});
    if (e_wb && m[4] && a[3])
      chk("R7", cexc[4] && cexc[3] && cexc[0], {11'b0, cexc}, {11'b0, e_cexc});
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; op_valid = 0; unfin_req = 0; mul_flags = 0; add_flags = 0;
    trap_en = 0; ns_mode = 0;
    for (int ns = 0; ns < 2; ns++) begin
      for (int ep = 0; ep < 6; ep++) begin
        logic [4:0] en;
        en = (ep == 0) ? 5'b0 : 5'(1 << (ep - 1));
        do_reset();
        for (int m = 0; m < 32; m++) begin
          for (int a = 0; a < 32; a++) begin
            bit v, u;
            v = ((m ^ a) % 5) != 0;
            u = ((m + a + ep) % 7) == 0;
            step(v, u, 5'(m), 5'(a), en, ns[0]);
          end
        end
      end
    end
    // Directed: multiply trap hides an add stage that would also trap.
    do_reset();
    step(1, 0, 5'b01000, 5'b10000, 5'b11000, 1);
    chk("R2", cexc == 5'b01001, {11'b0, cexc}, 16'h0009);
    // Directed: invalid from add with overflow from multiply.
    step(1, 0, 5'b01000, 5'b10000, 5'b00000, 1);
    chk("R7", cexc == 5'b11001 && aexc == 5'b11001, {6'b0, cexc, aexc}, {6'b0, 5'b11001, 5'b11001});
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule